// File: doc/BRIEF.md
# TDM PCM Serial Port

The block moves 8-bit companded samples for four voice channels between per-channel sample registers and a time-division-multiplexed PCM bus. The bus has one serial output, one serial input, a bit clock and per-channel transmit and receive frame syncs. The bit clock is the block clock. Outgoing bits leave on its rising edge. Incoming bits and frame syncs are sampled on its falling edge. The companding arithmetic is not part of this block.

A mode pin selects one of two slot assignments. In per-channel mode, each channel's own sync pair places its 8-bit transmit and receive slots anywhere in the frame. In chained mode, a single sync on channel 0 opens 32 consecutive bit times, and channels 0 to 3 follow one another in that window. Outside its own slots the port releases the output line and raises its slot strobe. This lets many devices share one bus.

Top module: `pcm_tdm_port`

## Requirements
- R1: With `mode32_i` low, each channel has its own slots. With `mode32_i` high, a single channel-0 sync produces four back-to-back channel slots in the order 0, 1, 2, 3.
- R2: In per-channel mode, a sync edge on `fsx_i[n]` is detected on a falling clock edge. Starting at the next rising edge, `tx_sample_i[n]` goes out on `dx_o` as 8 bits, one bit per rising edge, most significant bit first.
- R3: Each transmit byte is latched when its slot starts. A change on `tx_sample_i` during the slot does not alter the bits sent.
- R4: In per-channel mode, a sync edge on `fsr_i[n]` is detected on a falling edge. `dr_i` is then sampled on the next 8 falling edges, most significant bit first. The byte appears on `rx_sample_o[n]` at the eighth of those edges, and `rx_valid_o[n]` is high for exactly that one clock period.
- R5: In chained mode, a sync edge on `fsx_i[0]` sends channels 0 to 3 over 32 consecutive rising edges. Each channel's byte is latched at the start of its own 8-bit part. Syncs on `fsx_i[3:1]` have no effect.
- R6: In chained mode, a sync edge on `fsr_i[0]` receives channels 0 to 3 over 32 consecutive falling edges. Each channel's valid pulse comes right after its own eighth bit. Syncs on `fsr_i[3:1]` have no effect.
- R7: `dx_oe_o` is high and `tsx_no` is low in exactly the bit periods in which the port drives a slot bit. In all other periods `dx_oe_o` is low, `tsx_no` is high and `dx_o` is low.
- R8: A slot starts only on a low-to-high sync transition, sampled on a falling edge. A sync held high for several bit clocks starts one slot only.
- R9: While reset is low, `dx_oe_o` is low, `tsx_no` is high, `rx_valid_o` is all zero and every `rx_sample_o` byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus bit clock (rising: transmit, falling: sample) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode32_i | input | 1 | 1 = chained 32-bit slot mode, 0 = per-channel 8-bit slots |
| fsx_i | input | NUM_CH | Transmit frame syncs, one per channel |
| fsr_i | input | NUM_CH | Receive frame syncs, one per channel |
| dr_i | input | 1 | Serial receive data |
| tx_sample_i | input | NUM_CH x SAMPLE_W | Bytes to transmit, one per channel |
| dx_o | output | 1 | Serial transmit data (low when not enabled) |
| dx_oe_o | output | 1 | Output enable for the transmit pad |
| tsx_no | output | 1 | Active-low slot-occupancy strobe |
| rx_sample_o | output | NUM_CH x SAMPLE_W | Last received byte per channel |
| rx_valid_o | output | NUM_CH | One-clock pulse when a channel's byte updates |

## Verification
The bench places slots back to back with no gap, in reverse channel order. A design that lets one lane's end and the next lane's start interfere would then drop or repeat a bit, or show a one-period enable glitch. It also drives syncs on channels 1 to 3 in the middle of a chained frame. A design that does not gate these would start a second transmitter and corrupt DX or pulse a spurious valid. A held sync checks that the design detects edges and not levels, and a sample changed during a slot checks that the byte is latched at slot start. All-ones, all-zeros and single-bit bytes would expose a design that shifts the wrong way or loses the first or last bit.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    SLOT_PER_CH  = 1'b0,
    SLOT_CHAINED = 1'b1
  } slot_mode_e;
endpackage

// File: rtl/pcm_sync_edge.sv
// Falling-edge sync sampler with rise detection.
// HOLD_TO_RISE=1: rise held for the following rising-edge domain.
// HOLD_TO_RISE=0: rise valid at the current falling edge.
module pcm_sync_edge #(
  parameter int  W            = 4,
  parameter bit  HOLD_TO_RISE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] cur_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= sync_i;
  end

  if (HOLD_TO_RISE) begin : g_held
    logic [W-1:0] prev_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= cur_q;
    end
    assign rise_o = cur_q & ~prev_q;
  end else begin : g_now
    assign rise_o = sync_i & ~cur_q;
  end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                active_o,
  output logic                last_o,
  output logic                bit_o
);
  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      sh_q     <= sample_i;
      cnt_q    <= TOP_IDX;
      active_q <= 1'b1;
    end else if (active_q) begin
      sh_q  <= {sh_q[SAMPLE_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == '0);
  assign bit_o    = sh_q[SAMPLE_W-1];

  // slot closes after its last bit unless restarted
  assert_tx_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_o);
  // next bit is the one below the current, MSB first
  assert_tx_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o && !start_i) |=> (bit_o == $past(sh_q[SAMPLE_W-2])));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dr_i,
  output logic                last_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                active_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (active_q) begin
        sh_q  <= {sh_q[SAMPLE_W-2:0], dr_i};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) begin
          sample_o <= {sh_q[SAMPLE_W-2:0], dr_i};
          valid_o  <= 1'b1;
          active_q <= 1'b0;
        end
      end
      // a start on the last bit re-arms for a back-to-back slot
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= TOP_IDX;
      end
    end
  end

  assign last_o = active_q && (cnt_q == '0);

  assert_rx_pulse_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_rx_src_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(last_o));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_port_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             mode32_i,
  input  logic [NUM_CH-1:0]                fsx_i,
  input  logic [NUM_CH-1:0]                fsr_i,
  input  logic                             dr_i,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  tx_sample_i,
  output logic                             dx_o,
  output logic                             dx_oe_o,
  output logic                             tsx_no,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]  rx_sample_o,
  output logic [NUM_CH-1:0]                rx_valid_o
);
  slot_mode_e mode;
  assign mode = slot_mode_e'(mode32_i);

  logic [NUM_CH-1:0] fsx_rise, fsr_rise;
  logic [NUM_CH-1:0] tx_start, tx_active, tx_last, tx_bit;
  logic [NUM_CH-1:0] rx_start, rx_last;

  pcm_sync_edge #(.W(NUM_CH), .HOLD_TO_RISE(1'b1)) i_fsx_edge (
    .clk_i, .rst_ni, .sync_i(fsx_i), .rise_o(fsx_rise));
  pcm_sync_edge #(.W(NUM_CH), .HOLD_TO_RISE(1'b0)) i_fsr_edge (
    .clk_i, .rst_ni, .sync_i(fsr_i), .rise_o(fsr_rise));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    if (ch == 0) begin : g_head
      assign tx_start[ch] = fsx_rise[0];
      assign rx_start[ch] = fsr_rise[0];
    end else begin : g_link
      // chained mode: a lane starts when its predecessor ends
      assign tx_start[ch] = (mode == SLOT_CHAINED) ? tx_last[ch-1] : fsx_rise[ch];
      assign rx_start[ch] = (mode == SLOT_CHAINED) ? rx_last[ch-1] : fsr_rise[ch];

      assert_tx_chain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == SLOT_CHAINED && tx_last[ch-1]) |=> tx_active[ch]);
    end

    pcm_tx_lane #(.SAMPLE_W(SAMPLE_W)) i_tx (
      .clk_i, .rst_ni,
      .start_i (tx_start[ch]),
      .sample_i(tx_sample_i[ch]),
      .active_o(tx_active[ch]),
      .last_o  (tx_last[ch]),
      .bit_o   (tx_bit[ch]));

    pcm_rx_lane #(.SAMPLE_W(SAMPLE_W)) i_rx (
      .clk_i, .rst_ni,
      .start_i (rx_start[ch]),
      .dr_i,
      .last_o  (rx_last[ch]),
      .sample_o(rx_sample_o[ch]),
      .valid_o (rx_valid_o[ch]));
  end

  // lowest channel wins if per-channel slots overlap
  always_comb begin
    dx_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (tx_active[i]) dx_o = tx_bit[i];
    end
  end

  assign dx_oe_o = |tx_active;
  assign tsx_no  = ~dx_oe_o;

  assert_last_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_last) |-> (dx_oe_o && !tsx_no));
  assert_rx_last_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (|rx_last) |=> (|rx_valid_o));
endmodule

// File: tb/test_pcm_tdm_port.sv
module test_pcm_tdm_port;
  localparam int NUM_CH = 4;
  localparam int SW     = 8;
  localparam int FR     = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                      mode32;
  logic [NUM_CH-1:0]         fsx, fsr;
  logic                      dr;
  logic [NUM_CH-1:0][SW-1:0] tx_sample;
  logic                      dx, dx_oe, tsx_n;
  logic [NUM_CH-1:0][SW-1:0] rx_sample;
  logic [NUM_CH-1:0]         rx_valid;

  pcm_tdm_port #(.NUM_CH(NUM_CH), .SAMPLE_W(SW)) i_pcm_tdm_port (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(mode32), .fsx_i(fsx), .fsr_i(fsr),
    .dr_i(dr), .tx_sample_i(tx_sample), .dx_o(dx), .dx_oe_o(dx_oe),
    .tsx_no(tsx_n), .rx_sample_o(rx_sample), .rx_valid_o(rx_valid));

  int checks = 0;
  int errors = 0;

  logic [NUM_CH-1:0] fsx_pat [FR];
  logic [NUM_CH-1:0] fsr_pat [FR];
  logic              dr_pat  [FR];
  logic              oe_exp  [FR];
  logic              dx_exp  [FR];
  logic [NUM_CH-1:0] vld_exp [FR];
  logic [SW-1:0]     rx_exp  [NUM_CH];
  int                mut_cycle;
  string             tx_req, rx_req;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_plan();
    for (int c = 0; c < FR; c++) begin
      fsx_pat[c] = '0; fsr_pat[c] = '0; dr_pat[c] = 1'b0;
      oe_exp[c] = 1'b0; dx_exp[c] = 1'b0; vld_exp[c] = '0;
    end
    mut_cycle = -1;
  endtask

  // sync detected in cycle c: bits out in cycles c+1..c+8
  task automatic expect_tx(int c, logic [SW-1:0] b);
    for (int i = 0; i < SW; i++) begin
      oe_exp[c+1+i] = 1'b1;
      dx_exp[c+1+i] = b[SW-1-i];
    end
  endtask

  // sync detected in cycle c: DR bits in c+1..c+8, valid seen in c+9
  task automatic expect_rx(int c, int ch, logic [SW-1:0] b);
    for (int i = 0; i < SW; i++) dr_pat[c+1+i] = b[SW-1-i];
    vld_exp[c+SW+1][ch] = 1'b1;
    rx_exp[ch] = b;
  endtask

  task automatic plan_chained(int ct, int cr, logic [NUM_CH-1:0][SW-1:0] rxb);
    fsx_pat[ct][0] = 1'b1;
    fsr_pat[cr][0] = 1'b1;
    for (int k = 0; k < NUM_CH; k++) begin
      expect_tx(ct + SW*k, tx_sample[k]);
      expect_rx(cr + SW*k, k, rxb[k]);
    end
  endtask

  task automatic run_frame();
    for (int c = 0; c < FR; c++) begin
      @(posedge clk);
      #1;
      fsx = fsx_pat[c];
      fsr = fsr_pat[c];
      dr  = dr_pat[c];
      if (c == mut_cycle) tx_sample = ~tx_sample;
      #1;
      check("R7", "dx_oe", int'(dx_oe), int'(oe_exp[c]));
      check("R7", "tsx_n", int'(tsx_n), int'(!oe_exp[c]));
      check(oe_exp[c] ? tx_req : "R7", "dx", int'(dx), int'(dx_exp[c]));
      check(rx_req, "rx_valid", int'(rx_valid), int'(vld_exp[c]));
      for (int ch = 0; ch < NUM_CH; ch++)
        if (vld_exp[c][ch]) check(rx_req, "rx_sample", int'(rx_sample[ch]), int'(rx_exp[ch]));
    end
  endtask

  function automatic logic [SW-1:0] rnd_byte();
    return SW'($urandom);
  endfunction

  initial begin
    int perm [NUM_CH];
    logic [NUM_CH-1:0][SW-1:0] rxb;
    int ct, cr, j, t;
    void'($urandom(32'h5eed_0042));
    mode32 = 1'b0; fsx = '0; fsr = '0; dr = 1'b0; tx_sample = '0;

    // R9: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R9", "dx_oe", int'(dx_oe), 0);
    check("R9", "tsx_n", int'(tsx_n), 1);
    check("R9", "rx_valid", int'(rx_valid), 0);
    for (int ch = 0; ch < NUM_CH; ch++) check("R9", "rx_sample", int'(rx_sample[ch]), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 R2 R4: per-channel, back-to-back, reverse order, edge bytes
    clear_plan();
    mode32 = 1'b0; tx_req = "R1 R2"; rx_req = "R1 R4";
    tx_sample = {8'h80, 8'h01, 8'hFF, 8'h00};
    for (int k = 0; k < NUM_CH; k++) begin
      fsx_pat[2 + SW*k][NUM_CH-1-k] = 1'b1;
      expect_tx(2 + SW*k, tx_sample[NUM_CH-1-k]);
      fsr_pat[5 + SW*k][k] = 1'b1;
    end
    expect_rx(5, 0, 8'h80); expect_rx(13, 1, 8'h01);
    expect_rx(21, 2, 8'hFF); expect_rx(29, 3, 8'h00);
    run_frame();

    // R3: sample changed mid-slot is not sent
    clear_plan();
    tx_req = "R3"; rx_req = "R4";
    tx_sample = {8'h11, 8'hC3, 8'h5A, 8'h77};
    fsx_pat[3][2] = 1'b1;
    expect_tx(3, 8'hC3);
    mut_cycle = 6;
    run_frame();

    // R8: held syncs start one slot only
    clear_plan();
    tx_req = "R8"; rx_req = "R8";
    tx_sample = {8'h3C, 8'h96, 8'hE1, 8'h42};
    for (int c = 3; c < 7; c++) fsx_pat[c][1] = 1'b1;
    expect_tx(3, 8'hE1);
    for (int c = 20; c < 24; c++) fsr_pat[c][2] = 1'b1;
    expect_rx(20, 2, 8'hB7);
    run_frame();

    // R1 R5 R6: chained mode, stray syncs on other channels ignored
    clear_plan();
    mode32 = 1'b1; tx_req = "R1 R5"; rx_req = "R1 R6";
    tx_sample = {8'hA5, 8'h0F, 8'hF0, 8'h5A};
    rxb = {8'h81, 8'h7E, 8'hC0, 8'h03};
    plan_chained(3, 7, rxb);
    fsx_pat[20][1] = 1'b1; fsx_pat[45][2] = 1'b1;
    fsr_pat[25][2] = 1'b1; fsr_pat[46][3] = 1'b1;
    run_frame();

    // random rounds in both modes
    for (int r = 0; r < 16; r++) begin
      clear_plan();
      mode32 = 1'($urandom_range(1, 0));
      for (int ch = 0; ch < NUM_CH; ch++) tx_sample[ch] = rnd_byte();
      for (int ch = 0; ch < NUM_CH; ch++) rxb[ch] = rnd_byte();
      if (mode32) begin
        tx_req = "R5"; rx_req = "R6";
        plan_chained(int'($urandom_range(10, 2)), int'($urandom_range(10, 2)), rxb);
      end else begin
        tx_req = "R2"; rx_req = "R4";
        for (int i = 0; i < NUM_CH; i++) perm[i] = i;
        for (int i = NUM_CH - 1; i > 0; i--) begin
          j = int'($urandom_range(i, 0)); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        ct = 2 + int'($urandom_range(2, 0));
        for (int i = 0; i < NUM_CH; i++) begin
          fsx_pat[ct][perm[i]] = 1'b1;
          expect_tx(ct, tx_sample[perm[i]]);
          ct += SW + int'($urandom_range(2, 0));
        end
        for (int i = NUM_CH - 1; i > 0; i--) begin
          j = int'($urandom_range(i, 0)); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        cr = 2 + int'($urandom_range(2, 0));
        for (int i = 0; i < NUM_CH; i++) begin
          fsr_pat[cr][perm[i]] = 1'b1;
          expect_rx(cr, perm[i], rxb[perm[i]]);
          cr += SW + int'($urandom_range(2, 0));
        end
      end
      run_frame();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL all requirements watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule